// File: doc/BRIEF.md
# Per-Channel Committed-Rate Transmit Gate

This block holds a committed-rate value for each of eight transmit channels and decides, cycle by cycle, which channels may send. A rate is written as a fixed-point fraction of the bus word rate, scaled by `SCALE` (32768 by default). A value of `SCALE` stands for the full bus and a value of zero means the channel is not limited. Each limited channel keeps a signed credit. Every clock the credit grows by the channel's rate, and every transferred bus word takes `SCALE` away. The channel stays eligible while its credit is non-negative, so its long-run share of the bus cannot exceed rate/`SCALE`.

Limiting is only defined when the limited channels form one unbroken group that starts at the highest channel index and runs downward. Each register write rechecks this rule. While the rule is broken, a configuration-error output is raised and every channel runs unlimited. Arbitration among eligible channels and the data path belong to the surrounding logic.

Each channel runs a small state machine with three states:
- `CH_BYPASS`: the channel is unlimited.
- `CH_OPEN`: the channel is limited and its credit is non-negative.
- `CH_HELD`: the channel is limited and its credit is negative.

The transitions are:
- bypass-to-open, when a non-zero rate takes effect with no error;
- open-to-held, when a transfer drives the credit negative;
- held-to-open, when the credit climbs back to zero or above;
- any-to-bypass, when the rate is zero or the configuration error is set;
- write-to-open, when a write to that channel clears its credit.

Top module: `cir_tx_gate`

## Requirements
- R1: After reset every rate is zero, `cfg_err` is 0 and `eligible` equals `req`.
- R2: A channel whose rate is zero is eligible whenever it requests, however many words it transfers.
- R3: A channel that does not request is never eligible.
- R4: A limited channel's credit changes each clock by +rate, and by a further −`SCALE` in a clock where `xfer` is high. The channel is eligible in the cycle after an edge exactly when the credit left by that edge is ≥ 0. With `SCALE`=16 and rate 4, one transfer from zero credit leaves the channel ineligible for three cycles; it is eligible again after the fourth edge.
- R5: Credit saturates at `CEIL_WORDS`×`SCALE`, so a full-credit channel can send at most a bounded burst back to back. With `SCALE`=16, `CEIL_WORDS`=4 and rate 4, that burst is 6 words.
- R6: Writing a channel's rate register clears that channel's credit to zero, even when the value written is unchanged.
- R7: Each write recomputes `cfg_err`. The flag is 0 when the set of channels with a non-zero rate is empty or is {N−1, N−2, …, k} for some k, and 1 otherwise. Between writes it holds its value.
- R8: While `cfg_err` is 1, every channel is unlimited: it is eligible whenever it requests, regardless of its rate or its transfers.
- R9: A limited channel that transfers whenever it is eligible sends rate/`SCALE` of the cycles over a long run. With rate 4 and `SCALE`=16, that is 100 ±1 words in 400 cycles.
- R10: `wr_addr` value i selects the rate register of channel i. A write affects that channel only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Rate register write strobe |
| wr_addr | input | $clog2(NUM_CH) | Channel index of the rate register written |
| wr_data | input | RATE_W | New rate value, fraction of the bus scaled by SCALE |
| req | input | NUM_CH | Per-channel request to send |
| xfer | input | NUM_CH | Per-channel strobe: one bus word transferred this clock |
| eligible | output | NUM_CH | Per-channel permission to send |
| cfg_err | output | 1 | Limited channels are not a contiguous group from the top |

## Verification
The bench builds the block with `SCALE`=16 and `CEIL_WORDS`=4, and keeps the default eight channels and 16-bit rates. At that scale a rate of 4 is a quarter of the bus. The recovery gap after a single word, the 6-word saturated burst and the 100-in-400 throughput are therefore a few cycles long and can be predicted exactly by hand. The small ceiling also lets the credit saturate within a few dozen idle cycles, so the ceiling and the credit-clear-on-write behaviour are both visible within a short run.

// File: rtl/cir_pkg.sv
package cir_pkg;

    typedef enum logic [1:0] {
        CH_BYPASS = 2'd0,
        CH_OPEN   = 2'd1,
        CH_HELD   = 2'd2
    } ch_state_e;

    // Non-zero-rate mask is legal when it is empty or a run of ones
    // reaching the top bit of an n-bit field.
    function automatic logic mask_is_top_run(input logic [31:0] m, input int n);
        logic [32:0] inv;
        logic [32:0] lim;
        lim = (33'd1 << n) - 33'd1;
        inv = {1'b0, ~m} & lim;
        return ((inv & (inv + 33'd1)) & lim) == 33'd0;
    endfunction

endpackage

// File: rtl/cir_rate_regs.sv
module cir_rate_regs
    import cir_pkg::*;
#(
    parameter int NUM_CH = 8,
    parameter int RATE_W = 16,
    localparam int AW    = $clog2(NUM_CH)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [AW-1:0]                  wr_addr,
    input  logic [RATE_W-1:0]              wr_data,
    output logic [NUM_CH-1:0][RATE_W-1:0]  rate,
    output logic [NUM_CH-1:0]              clr,
    output logic                           cfg_err
);

    logic [NUM_CH-1:0] live_mask;
    logic [NUM_CH-1:0] next_mask;

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_reg
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n)
                    rate[g] <= '0;
                else if (clr[g])
                    rate[g] <= wr_data;
            end

            assign clr[g]       = wr_en && (wr_addr == AW'(g));
            assign live_mask[g] = (rate[g] != '0);
            assign next_mask[g] = clr[g] ? (wr_data != '0) : live_mask[g];
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cfg_err <= 1'b0;
        else if (wr_en)
            cfg_err <= !mask_is_top_run(32'(next_mask), NUM_CH);
    end

    // R7: the flag only moves on a write
    p_err_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(cfg_err));

    // R10: at most one register is selected per write
    p_one_target_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(clr));

endmodule

// File: rtl/cir_credit_chan.sv
module cir_credit_chan
    import cir_pkg::*;
#(
    parameter int RATE_W     = 16,
    parameter int SCALE      = 32768,
    parameter int CEIL_WORDS = 4,
    localparam int CW = $clog2(CEIL_WORDS * SCALE + 2 * SCALE + (2 ** RATE_W)) + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [RATE_W-1:0] rate,
    input  logic              cfg_err,
    input  logic              xfer,
    output logic              held
);

    localparam logic signed [CW-1:0] CEIL_C  = CW'(CEIL_WORDS * SCALE);
    localparam logic signed [CW-1:0] COST_C  = CW'(SCALE);
    localparam logic signed [CW-1:0] FLOOR_C = -COST_C;

    ch_state_e              state_q, state_d;
    logic signed [CW-1:0]   credit_q, credit_d;
    logic signed [CW-1:0]   rate_ext;
    logic signed [CW-1:0]   sum;
    logic                   bypass;

    assign rate_ext = {{(CW-RATE_W){1'b0}}, rate};
    assign bypass   = (rate == '0) || cfg_err;
    assign sum      = credit_q + rate_ext - (xfer ? COST_C : '0);

    // next-state and credit
    always_comb begin
        state_d  = state_q;
        credit_d = credit_q;
        if (clr) begin
            state_d  = CH_OPEN;
            credit_d = '0;
        end else if (bypass) begin
            state_d  = CH_BYPASS;
            credit_d = '0;
        end else begin
            if (sum > CEIL_C)
                credit_d = CEIL_C;
            else if (sum < FLOOR_C)
                credit_d = FLOOR_C;
            else
                credit_d = sum;
            unique case (state_q)
                CH_BYPASS: state_d = (credit_d < 0) ? CH_HELD : CH_OPEN;
                CH_OPEN:   state_d = (credit_d < 0) ? CH_HELD : CH_OPEN;
                CH_HELD:   state_d = (credit_d < 0) ? CH_HELD : CH_OPEN;
                default:   state_d = CH_BYPASS;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= CH_BYPASS;
            credit_q <= '0;
        end else begin
            state_q  <= state_d;
            credit_q <= credit_d;
        end
    end

    // outputs
    always_comb begin
        unique case (state_q)
            CH_HELD: held = 1'b1;
            default: held = 1'b0;
        endcase
    end

    p_ceiling_r5: assert property (@(posedge clk) disable iff (!rst_n)
        credit_q <= CEIL_C);

    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (credit_q == 0) && (state_q == CH_OPEN));

    // R2 / R8: unlimited channels drop to bypass with no credit
    p_bypass_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && bypass) |=> (state_q == CH_BYPASS) && (credit_q == 0));

    p_held_sign_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CH_HELD) |-> (credit_q < 0));

endmodule

// File: rtl/cir_tx_gate.sv
module cir_tx_gate
    import cir_pkg::*;
#(
    parameter int NUM_CH     = 8,
    parameter int RATE_W     = 16,
    parameter int SCALE      = 32768,
    parameter int CEIL_WORDS = 4,
    localparam int AW        = $clog2(NUM_CH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [RATE_W-1:0] wr_data,
    input  logic [NUM_CH-1:0] req,
    input  logic [NUM_CH-1:0] xfer,
    output logic [NUM_CH-1:0] eligible,
    output logic              cfg_err
);

    logic [NUM_CH-1:0][RATE_W-1:0] rate;
    logic [NUM_CH-1:0]             clr;
    logic [NUM_CH-1:0]             held;

    cir_rate_regs #(
        .NUM_CH (NUM_CH),
        .RATE_W (RATE_W)
    ) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rate    (rate),
        .clr     (clr),
        .cfg_err (cfg_err)
    );

    generate
        for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
            cir_credit_chan #(
                .RATE_W     (RATE_W),
                .SCALE      (SCALE),
                .CEIL_WORDS (CEIL_WORDS)
            ) i_chan (
                .clk     (clk),
                .rst_n   (rst_n),
                .clr     (clr[g]),
                .rate    (rate[g]),
                .cfg_err (cfg_err),
                .xfer    (xfer[g]),
                .held    (held[g])
            );
        end
    endgenerate

    assign eligible = req & ~held;

    p_need_req_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (eligible & ~req) == '0);

endmodule

// File: tb/test_cir_tx_gate.sv
module test_cir_tx_gate;

    localparam int NCH = 8;
    localparam int RW  = 16;
    localparam int SC  = 16;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           wr_en = 1'b0;
    logic [2:0]     wr_addr = '0;
    logic [RW-1:0]  wr_data = '0;
    logic [NCH-1:0] req = '0;
    logic [NCH-1:0] xfer = '0;
    logic [NCH-1:0] eligible;
    logic           cfg_err;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    cir_tx_gate #(
        .NUM_CH     (NCH),
        .RATE_W     (RW),
        .SCALE      (SC),
        .CEIL_WORDS (4)
    ) i_cir_tx_gate (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .req      (req),
        .xfer     (xfer),
        .eligible (eligible),
        .cfg_err  (cfg_err)
    );

    task automatic chk(input logic ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wr(input int ch, input int val);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(ch); wr_data = RW'(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset();
        req = 8'hA5;
        @(negedge clk);
        chk(eligible == 8'hA5, "R1 eligible follows req", eligible, 8'hA5);
        chk(cfg_err == 1'b0, "R1 cfg_err clear", cfg_err, 0);
    endtask

    task automatic t_unlimited();
        int lows = 0;
        req = 8'hFF;
        xfer[2] = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (!eligible[2]) lows++;
        end
        xfer[2] = 1'b0;
        chk(lows == 0, "R2 zero rate never held", lows, 0);
        req = 8'h7F;
        @(negedge clk);
        chk(eligible[7] == 1'b0, "R3 no request no grant", eligible[7], 0);
        req = 8'hFF;
    endtask

    task automatic t_recover();
        logic [3:0] seen;
        wr(7, 4);
        chk(eligible[7] == 1'b1, "R6 open after write", eligible[7], 1);
        xfer[7] = 1'b1;
        @(negedge clk);
        xfer[7] = 1'b0;
        seen[0] = eligible[7];
        for (int i = 1; i < 4; i++) begin
            @(negedge clk);
            seen[i] = eligible[7];
        end
        chk(seen == 4'b1000, "R4 recovery after fourth edge", seen, 4'b1000);
        chk(cfg_err == 1'b0, "R7 top channel alone legal", cfg_err, 0);
    endtask

    task automatic t_burst();
        int cnt = 0;
        repeat (20) @(negedge clk);
        for (int i = 0; i < 20; i++) begin
            if (!eligible[7]) break;
            xfer[7] = 1'b1;
            @(negedge clk);
            xfer[7] = 1'b0;
            cnt++;
        end
        chk(cnt == 6, "R5 saturated burst", cnt, 6);
    endtask

    task automatic t_clear();
        repeat (30) @(negedge clk);
        wr(7, 4);
        xfer[7] = 1'b1;
        @(negedge clk);
        xfer[7] = 1'b0;
        chk(eligible[7] == 1'b0, "R6 rewrite cleared credit", eligible[7], 0);
    endtask

    task automatic t_rate();
        int cnt = 0;
        wr(7, 4);
        for (int i = 0; i < 400; i++) begin
            xfer[7] = eligible[7];
            @(negedge clk);
            if (xfer[7]) cnt++;
        end
        xfer[7] = 1'b0;
        chk(cnt >= 99 && cnt <= 101, "R9 long-run share", cnt, 100);
    endtask

    task automatic t_cfg_err();
        int lows = 0;
        wr(0, 4);
        chk(cfg_err == 1'b1, "R7 gap in limited set flagged", cfg_err, 1);
        @(negedge clk);
        xfer[7] = 1'b1; xfer[0] = 1'b1;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (eligible[7] != 1'b1 || eligible[0] != 1'b1) lows++;
        end
        xfer = '0;
        chk(lows == 0, "R8 all unlimited under error", lows, 0);
        wr(0, 0);
        chk(cfg_err == 1'b0, "R7 error cleared by rewrite", cfg_err, 0);
    endtask

    task automatic t_addr();
        wr(6, 2);
        chk(cfg_err == 1'b0, "R7 two top channels legal", cfg_err, 0);
        @(negedge clk);
        xfer[6] = 1'b1; xfer[5] = 1'b1;
        @(negedge clk);
        xfer = '0;
        chk(eligible[6] == 1'b0, "R10 channel 6 limited", eligible[6], 0);
        chk(eligible[5] == 1'b1, "R10 channel 5 untouched", eligible[5], 1);
        wr(4, 3);
        chk(cfg_err == 1'b1, "R7 skipped channel 5 flagged", cfg_err, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_unlimited();
        t_recover();
        t_burst();
        t_clear();
        t_rate();
        t_cfg_err();
        t_addr();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule